// File: doc/BRIEF.md
# Seeded Pseudo-Random Stall Generator

This block produces a single stall line for an accelerator core, so that the core's timing profile is randomised and harder to observe from outside. When stalling is switched on, the line either follows a stall request arriving from the surrounding fabric, or comes from an internal generator. The internal generator is a 32-bit pseudo-random shift register that software seeds.

In internal mode, a 2-bit rate code sets the average stall density to one cycle in 8, 16, 32 or 64. A stall is raised when a rate-dependent number of low register bits are all zero. A seed of zero is replaced by a fixed nonzero constant, so the register can never lock up. The register takes the seed on reset and whenever the load strobe pulses. The output is registered.

Top module: `stall_gen`

## Requirements
- R1: During synchronous reset (rst_n low at a rising edge), stall_out is 0 after that edge, and the shift register is loaded from the seed input (with the R5 substitution).
- R2: While not loading, the shift register steps once per clock as a right-shifting Galois register: next = (state >> 1) XOR (state[0] ? 32'h8020_0003 : 0).
- R3: With stall_en=1 and int_mode=0, stall_out after an edge equals fab_stall sampled at that edge.
- R4: With stall_en=0, stall_out is 0 after the edge, whatever the mode, fabric input or register state.
- R5: A seed value of zero is replaced by 32'h9E37_79B9 when it is loaded, and the register never holds zero.
- R6: seed_load=1 at an edge loads the seed (with the R5 substitution) into the register instead of stepping it.
- R7: With stall_en=1 and int_mode=1, stall_out after an edge is 1 exactly when the low K register bits before that edge are all zero. K is 3, 4, 5 or 6 for rate_sel 00, 01, 10 or 11.
- R8: stall_out is a register output with one cycle of latency from its inputs and the register state. Over long runs the internal stall density approaches 1 in 2^K.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_en | input | 1 | Global stall enable |
| int_mode | input | 1 | 1: internal generator, 0: fabric stall passthrough |
| rate_sel | input | 2 | Internal rate code (00=1/8, 01=1/16, 10=1/32, 11=1/64) |
| seed | input | 32 | Seed value for the shift register |
| seed_load | input | 1 | Strobe that reloads the register from seed |
| fab_stall | input | 1 | External stall request |
| stall_out | output | 1 | Registered stall to the core |

## Verification
The bench keeps its own bit-by-bit model of the shift register and compares the stall line on every cycle. It drives all four rate codes, so a design with a wrong mask width stalls at a rate that is off by a factor of two. The bench loads a zero seed and runs internal mode: a design without the substitution locks up and stalls on every cycle. It also reloads the seed mid-run and toggles the mode and enable on single cycles. These catch a design that steps the register on a load edge, or that gives the output an extra or a missing register stage.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int unsigned LFSR_W   = 32;
  localparam int unsigned RATE_W   = 2;
  localparam int unsigned MIN_BITS = 3;
  localparam int unsigned MASK_W   = MIN_BITS + (1 << RATE_W) - 1;
  localparam logic [LFSR_W-1:0] TAP_MASK      = 32'h8020_0003;
  localparam logic [LFSR_W-1:0] ZERO_SEED_SUB = 32'h9E37_79B9;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? TAP_MASK : '0);
  endfunction

  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
    return (s == '0) ? ZERO_SEED_SUB : s;
  endfunction

  function automatic logic [MASK_W-1:0] rate_mask(input logic [RATE_W-1:0] r);
    int unsigned n;
    n = MIN_BITS + int'(r);
    return MASK_W'((64'd1 << n) - 64'd1);
  endfunction
endpackage

// File: rtl/stall_lfsr.sv
module stall_lfsr
  import stall_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LFSR_W-1:0] seed,
  input  logic              seed_load,
  output logic [LFSR_W-1:0] state,
  output logic              load_evt
);
  assign load_evt = !rst_n || seed_load;

  always_ff @(posedge clk) begin
    if (load_evt) state <= seed_fix(seed);
    else          state <= lfsr_step(state);
  end
endmodule

// File: rtl/stall_rate_match.sv
module stall_rate_match
  import stall_pkg::*;
(
  input  logic [MASK_W-1:0] low_bits,
  input  logic [RATE_W-1:0] rate_sel,
  output logic              hit
);
  logic [MASK_W-1:0] mask;
  assign mask = rate_mask(rate_sel);
  assign hit  = (low_bits & mask) == '0;
endmodule

// File: rtl/stall_gen.sv
module stall_gen
  import stall_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_en,
  input  logic              int_mode,
  input  logic [1:0]        rate_sel,
  input  logic [31:0]       seed,
  input  logic              seed_load,
  input  logic              fab_stall,
  output logic              stall_out
);
  logic [LFSR_W-1:0] lfsr_state;
  logic              load_evt;
  logic              int_hit;
  logic              stall_next;

  stall_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .seed(seed), .seed_load(seed_load),
    .state(lfsr_state), .load_evt(load_evt)
  );

  stall_rate_match u_match (
    .low_bits(lfsr_state[MASK_W-1:0]), .rate_sel(rate_sel), .hit(int_hit)
  );

  assign stall_next = stall_en && (int_mode ? int_hit : fab_stall);

  always_ff @(posedge clk) begin
    if (!rst_n) stall_out <= 1'b0;
    else        stall_out <= stall_next;
  end
endmodule

// File: rtl/stall_gen_chk.sv
module stall_gen_chk
  import stall_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              stall_en,
  input logic              int_mode,
  input logic [31:0]       seed,
  input logic              seed_load,
  input logic              fab_stall,
  input logic              stall_out,
  input logic              int_hit,
  input logic [LFSR_W-1:0] lfsr_state
);
  a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_en |=> !stall_out);

  a_r3_fabric_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_en && !int_mode) |=> (stall_out == $past(fab_stall)));

  a_r7_internal_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_en && int_mode) |=> (stall_out == $past(int_hit)));

  a_r5_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != '0);

  a_r6_seed_load: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (lfsr_state == (($past(seed) == 32'd0) ? ZERO_SEED_SUB : $past(seed))));

  a_r2_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !seed_load |=> (lfsr_state != $past(lfsr_state)));
endmodule

bind stall_gen stall_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stall_en(stall_en), .int_mode(int_mode),
  .seed(seed), .seed_load(seed_load), .fab_stall(fab_stall),
  .stall_out(stall_out), .int_hit(int_hit), .lfsr_state(lfsr_state)
);

// File: tb/stall_gen_tb.sv
`timescale 1ns/100ps
module stall_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stall_en = 1'b0;
  logic        int_mode = 1'b0;
  logic [1:0]  rate_sel = 2'b00;
  logic [31:0] seed = 32'h1234_5678;
  logic        seed_load = 1'b0;
  logic        fab_stall = 1'b0;
  logic        stall_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] m_state;
  int stall_cnt;

  always #2.5 clk = ~clk;

  stall_gen u_dut (
    .clk(clk), .rst_n(rst_n), .stall_en(stall_en), .int_mode(int_mode),
    .rate_sel(rate_sel), .seed(seed), .seed_load(seed_load),
    .fab_stall(fab_stall), .stall_out(stall_out)
  );

  function automatic logic [31:0] m_next(input logic [31:0] s);
    logic [31:0] taps;
    logic [31:0] r;
    taps = 32'h8020_0003;
    for (int i = 0; i < 31; i++) r[i] = s[i+1] ^ (s[0] & taps[i]);
    r[31] = s[0] & taps[31];
    return r;
  endfunction

  function automatic bit m_hit(input logic [31:0] s, input logic [1:0] r);
    int k;
    k = 3 + r;
    for (int i = 0; i < k; i++) if (s[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: stall_out=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model consumes inputs at the edge, output compared just after
  task automatic step(input string req);
    logic exp;
    @(posedge clk);
    if (!rst_n) exp = 1'b0;
    else exp = stall_en && (int_mode ? m_hit(m_state, rate_sel) : fab_stall);
    if (!rst_n || seed_load) m_state = (seed == 32'd0) ? 32'h9E37_79B9 : seed;
    else m_state = m_next(m_state);
    #1;
    check(req, stall_out, exp);
    if (stall_out) stall_cnt++;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; stall_en = 1'b1; int_mode = 1'b0; fab_stall = 1'b1;
    for (int i = 0; i < 3; i++) step("R1");
    rst_n = 1'b1;
  endtask

  task automatic t_disabled();
    stall_en = 1'b0;
    for (int i = 0; i < 40; i++) begin
      int_mode = i[0]; fab_stall = 1'b1; rate_sel = 2'b00;
      step("R4");
    end
  endtask

  task automatic t_fabric();
    stall_en = 1'b1; int_mode = 1'b0;
    for (int i = 0; i < 32; i++) begin
      fab_stall = (i % 3 == 0) || (i % 5 == 1);
      step("R3");
    end
  endtask

  task automatic t_internal(input logic [1:0] r, input int n);
    stall_en = 1'b1; int_mode = 1'b1; rate_sel = r; stall_cnt = 0;
    for (int i = 0; i < n; i++) step("R7");
  endtask

  task automatic t_density(input logic [1:0] r);
    int lo, hi, per;
    per = 8 << r;
    t_internal(r, 8192);
    lo = 8192 / per / 2; hi = 8192 / per * 2;
    checks++;
    if (stall_cnt < lo || stall_cnt > hi) begin
      errors++;
      $display("FAIL R8: %0d stalls in 8192 cycles, expected about %0d", stall_cnt, 8192 / per);
    end
  endtask

  task automatic t_reload();
    seed = 32'hCAFE_F00D; seed_load = 1'b1; step("R6");
    seed_load = 1'b0; seed = 32'h0;
    t_internal(2'b00, 200);
    seed = 32'hCAFE_F00D; seed_load = 1'b1; step("R6");
    seed_load = 1'b0;
    t_internal(2'b01, 100);
  endtask

  task automatic t_zero_seed();
    seed = 32'h0; seed_load = 1'b1; step("R5");
    seed_load = 1'b0;
    t_internal(2'b00, 300);
    checks++;
    if (stall_cnt > 150) begin
      errors++;
      $display("FAIL R5: %0d stalls in 300 cycles, expected about 37", stall_cnt);
    end
    seed = 32'h5A5A_0001;
  endtask

  task automatic t_toggle();
    stall_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      int_mode = (i % 4) != 0; stall_en = (i % 7) != 3;
      fab_stall = i[1]; rate_sel = i[2:1];
      step("R2");
    end
  endtask

  task automatic t_reset_reload();
    seed = 32'h0; rst_n = 1'b0; step("R1");
    rst_n = 1'b1;
    t_internal(2'b10, 200);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_disabled();
    t_fabric();
    t_internal(2'b00, 500);
    t_internal(2'b01, 500);
    t_internal(2'b10, 500);
    t_internal(2'b11, 500);
    t_reload();
    t_zero_seed();
    t_toggle();
    t_reset_reload();
    for (int r = 0; r < 4; r++) t_density(2'(r));
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule